// File: doc/BRIEF.md
# Timer Input Capture Unit

This block watches one external input and, when the selected kind of edge appears on it, stores the value of a free-running timer in a capture register. The stored value is the timestamp that software reads to measure periods, pulse widths or event times. A four-bit mode input picks the kind of edge: a falling edge, a rising edge, or every fourth or every sixteenth rising edge. The last two modes use a small prescaler counter.

The input pin is asynchronous to the system clock. It first passes through a synchronizer chain, and edges are detected on the synchronized copy. Each capture sets a sticky event flag. The flag stays set until a clear strobe removes it, and a capture in the same cycle as a clear wins over the clear. The prescaler counter is emptied whenever the unit is off or the mode code is not a capture code. It is not emptied when the mode moves directly from one divided setting to the other, so the first capture after such a switch can come early.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset the capture value reads 0 and the event flag reads 0.
- R2: In mode 4'b0101, when the pin is first sampled high at clock edge k, the capture value takes the timer value present at clock edge k+2, and the flag sets at that same edge.
- R3: In mode 4'b0100, a high-to-low change of the pin captures with the same two-edge latency. Rising edges cause no capture in this mode.
- R4: In mode 4'b0110, only every fourth rising edge counted by the prescaler captures. Starting from an empty prescaler, the fourth edge is the first that captures.
- R5: In mode 4'b0111, only every sixteenth rising edge captures. Starting from an empty prescaler, the sixteenth edge is the first that captures.
- R6: The flag stays set until flag_clr_i is high at a clock edge. It then reads 0 after that edge, provided no capture happens at the same edge.
- R7: When a capture and flag_clr_i fall on the same clock edge, the flag remains set.
- R8: A later capture overwrites the capture value whether or not software read the earlier one. Without a capture, the value is held.
- R9: In mode 4'b0000, or any code outside 4'b0100 to 4'b0111, edges neither capture nor set the flag, and the prescaler is emptied.
- R10: A direct switch between modes 4'b0110 and 4'b0111 keeps the prescaler count. After three edges in 4'b0110, the thirteenth edge after switching to 4'b0111 is the first that captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | External event input, asynchronous |
| timer_i | input | 16 | Free-running timer value |
| mode_i | input | 4 | Capture mode select |
| flag_clr_i | input | 1 | Strobe that clears the event flag |
| cap_value_o | output | 16 | Capture register read data |
| flag_o | output | 1 | Sticky capture event flag |

## Verification
The hardest state to reach from the ports is the prescaler holding a non-zero count while the mode changes between the two divided settings (R10). The stimulus reaches it in three steps. It first empties the counter by passing through the off mode. It then applies exactly three rising pulses in the divide-by-four mode, and finally switches modes while the pin is low. The second difficult case is a clear strobe that lands on the capture edge itself (R7). For this the bench raises the clear exactly two cycles after raising the pin, so that it meets the end of the synchronizer latency.

// File: rtl/cap_pkg.sv
package cap_pkg;

   localparam logic [3:0] MODE_OFF   = 4'b0000;
   localparam logic [3:0] MODE_FALL  = 4'b0100;
   localparam logic [3:0] MODE_RISE  = 4'b0101;
   localparam logic [3:0] MODE_DIVLO = 4'b0110;
   localparam logic [3:0] MODE_DIVHI = 4'b0111;

   typedef enum logic [2:0] {
      SEL_IDLE  = 3'd0,
      SEL_FALL  = 3'd1,
      SEL_RISE  = 3'd2,
      SEL_DIVLO = 3'd3,
      SEL_DIVHI = 3'd4
   } ev_sel_e;

   function automatic ev_sel_e decode_mode(input logic [3:0] m);
      ev_sel_e s;
      case (m)
         MODE_FALL:  s = SEL_FALL;
         MODE_RISE:  s = SEL_RISE;
         MODE_DIVLO: s = SEL_DIVLO;
         MODE_DIVHI: s = SEL_DIVHI;
         default:    s = SEL_IDLE;
      endcase
      return s;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o,
   output logic fall_o
);
   localparam int LAST = STAGES;

   logic [LAST:0] sh_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("cap_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[0] <= 1'b0;
      else        sh_q[0] <= d_i;
   end

   for (genvar i = 1; i <= LAST; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q[i] <= 1'b0;
         else        sh_q[i] <= sh_q[i-1];
      end
   end

   assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];
   assign fall_o = ~sh_q[LAST-1] & sh_q[LAST];

   AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o) else $error("rise lasted more than one cycle"); // R2
   AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o) else $error("fall lasted more than one cycle"); // R3

endmodule

// File: rtl/cap_qual.sv
module cap_qual
   import cap_pkg::*;
#(
   parameter int DIV_LO = 4,
   parameter int DIV_HI = 16
) (
   input  logic    clk,
   input  logic    rst_n,
   input  ev_sel_e sel_i,
   input  logic    rise_i,
   input  logic    fall_i,
   output logic    fire_o
);
   localparam int PW   = $clog2(DIV_HI);
   localparam int LO_W = $clog2(DIV_LO);

   if (!is_pow2(DIV_LO) || !is_pow2(DIV_HI) || DIV_LO < 2 || DIV_LO >= DIV_HI) begin : g_bad_div
      $error("cap_qual: dividers must be powers of two with 2 <= DIV_LO < DIV_HI");
   end

   logic [PW-1:0] cnt_q;
   logic          divided;
   logic          lo_wrap;
   logic          hi_wrap;

   assign divided = (sel_i == SEL_DIVLO) || (sel_i == SEL_DIVHI);
   assign lo_wrap = (cnt_q[LO_W-1:0] == {LO_W{1'b1}});
   assign hi_wrap = (cnt_q == {PW{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (sel_i == SEL_IDLE) cnt_q <= '0;
      else if (divided && rise_i) cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      unique case (sel_i)
         SEL_FALL:  fire_o = fall_i;
         SEL_RISE:  fire_o = rise_i;
         SEL_DIVLO: fire_o = rise_i & lo_wrap;
         SEL_DIVHI: fire_o = rise_i & hi_wrap;
         default:   fire_o = 1'b0;
      endcase
   end

   AST_IDLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SEL_IDLE) |=> (cnt_q == '0)) else $error("prescaler not emptied"); // R9
   AST_IDLE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == SEL_IDLE) |-> !fire_o) else $error("fire while idle"); // R9
   AST_LO_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && sel_i == SEL_DIVLO) |=> (cnt_q[LO_W-1:0] == '0)) else $error("low divider misaligned"); // R4
   AST_HI_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_o && sel_i == SEL_DIVHI) |=> (cnt_q == '0)) else $error("high divider misaligned"); // R5
   AST_KEEP_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (divided && !rise_i) |=> $stable(cnt_q)) else $error("prescaler changed without edge"); // R10

endmodule

// File: rtl/cap_hold.sv
module cap_hold #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire_i,
   input  logic [TW-1:0] timer_i,
   input  logic          clr_i,
   output logic [TW-1:0] value_o,
   output logic          flag_o
);
   if (TW < 1) begin : g_bad_tw
      $error("cap_hold: TW must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      value_o <= '0;
      else if (fire_i) value_o <= timer_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (fire_i) flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end

   AST_VALUE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> (value_o == $past(timer_i))) else $error("capture missed timer"); // R2
   AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fire_i |=> $stable(value_o)) else $error("value changed without capture"); // R8
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o) else $error("flag dropped without clear"); // R6
   AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && clr_i) |=> flag_o) else $error("clear beat capture"); // R7

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
   import cap_pkg::*;
#(
   parameter int TW          = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_LO      = 4,
   parameter int DIV_HI      = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pin_i,
   input  logic [TW-1:0] timer_i,
   input  logic [3:0]    mode_i,
   input  logic          flag_clr_i,
   output logic [TW-1:0] cap_value_o,
   output logic          flag_o
);
   ev_sel_e sel;
   logic    rise;
   logic    fall;
   logic    fire;

   assign sel = decode_mode(mode_i);

   cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (pin_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   cap_qual #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (sel),
      .rise_i (rise),
      .fall_i (fall),
      .fire_o (fire)
   );

   cap_hold #(.TW(TW)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (fire),
      .timer_i (timer_i),
      .clr_i   (flag_clr_i),
      .value_o (cap_value_o),
      .flag_o  (flag_o)
   );

   AST_FALL_MODE_IGNORES_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_FALL && rise && !flag_o) |=> !flag_o) else $error("rise captured in fall mode"); // R3

endmodule

// File: tb/sim_edge_capture_unit.sv
`timescale 1ns/1ps
module sim_edge_capture_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_i = 1'b0;
   logic [15:0] timer_i = 16'h0;
   logic [3:0]  mode_i = 4'b0000;
   logic        flag_clr_i = 1'b0;
   logic [15:0] cap_value_o;
   logic        flag_o;

   int    errors = 0;
   int    checks = 0;
   bit    done = 0;
   string tag = "R1";

   // reference model state
   int          m_s1, m_s2, m_s3, m_cnt;
   logic [15:0] m_cap;
   bit          m_flag;

   always #2 clk = ~clk;

   edge_capture_unit u0 (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .timer_i(timer_i),
      .mode_i(mode_i), .flag_clr_i(flag_clr_i),
      .cap_value_o(cap_value_o), .flag_o(flag_o)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_cap = '0; m_flag = 0;
      end else begin
         bit r, f, fire;
         r = (m_s2 == 1) && (m_s3 == 0);
         f = (m_s2 == 0) && (m_s3 == 1);
         fire = 0;
         case (mode_i)
            4'b0100: fire = f;
            4'b0101: fire = r;
            4'b0110: if (r) begin fire = (m_cnt % 4 == 3); m_cnt = (m_cnt + 1) % 16; end
            4'b0111: if (r) begin fire = (m_cnt == 15);    m_cnt = (m_cnt + 1) % 16; end
            default: m_cnt = 0;
         endcase
         if (fire) begin m_cap = timer_i; m_flag = 1; end
         else if (flag_clr_i) m_flag = 0;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_i;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag, {16'h0, cap_value_o}, {16'h0, m_cap}, "capture value vs model");
         check(tag, {31'h0, flag_o}, {31'h0, m_flag}, "flag vs model");
      end
   end

   // timer runs with an odd stride so captured values differ
   always @(negedge clk) timer_i <= timer_i + 16'd7;

   task automatic pulse();
      pin_i = 1'b1;
      repeat (5) @(negedge clk);
      pin_i = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic clear_flag();
      flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic go_off();
      mode_i = 4'b0000;
      repeat (2) @(negedge clk);
      clear_flag();
   endtask

   initial begin
      #(4.0 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] v1;
      repeat (4) @(negedge clk);
      tag = "R1";
      check("R1", {16'h0, cap_value_o}, 32'h0, "reset capture value");
      check("R1", {31'h0, flag_o}, 32'h0, "reset flag");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: rising-edge capture
      tag = "R2";
      mode_i = 4'b0101;
      @(negedge clk);
      pulse();
      check("R2", {31'h0, flag_o}, 32'h1, "flag after rising edge");
      pulse(); pulse();

      // R6: sticky then cleared
      tag = "R6";
      repeat (6) @(negedge clk);
      check("R6", {31'h0, flag_o}, 32'h1, "flag held while idle");
      clear_flag();
      check("R6", {31'h0, flag_o}, 32'h0, "flag after clear");

      // R3: falling-edge capture, rising edge ignored
      tag = "R3";
      mode_i = 4'b0100;
      @(negedge clk);
      pin_i = 1'b1;
      repeat (5) @(negedge clk);
      check("R3", {31'h0, flag_o}, 32'h0, "rising edge ignored in fall mode");
      pin_i = 1'b0;
      repeat (5) @(negedge clk);
      check("R3", {31'h0, flag_o}, 32'h1, "flag after falling edge");
      pulse();

      // R8: overwrite without reading
      tag = "R8";
      v1 = cap_value_o;
      pulse();
      check("R8", {31'h0, (cap_value_o != v1)}, 32'h1, "value overwritten");

      // R7: clear lands on capture edge
      tag = "R7";
      mode_i = 4'b0101;
      clear_flag();
      pin_i = 1'b1;
      repeat (2) @(negedge clk);
      flag_clr_i = 1'b1;
      @(negedge clk);
      flag_clr_i = 1'b0;
      check("R7", {31'h0, flag_o}, 32'h1, "capture beats clear");
      repeat (3) @(negedge clk);
      pin_i = 1'b0;
      repeat (5) @(negedge clk);

      // R9: off and non-capture codes
      tag = "R9";
      go_off();
      v1 = cap_value_o;
      pulse(); pulse();
      mode_i = 4'b1010;
      pulse();
      mode_i = 4'b0010;
      pulse();
      check("R9", {31'h0, flag_o}, 32'h0, "no flag while not capturing");
      check("R9", {16'h0, cap_value_o}, {16'h0, v1}, "value unchanged while not capturing");

      // R4: every fourth rising edge
      tag = "R4";
      go_off();
      mode_i = 4'b0110;
      @(negedge clk);
      for (int i = 0; i < 3; i++) pulse();
      check("R4", {31'h0, flag_o}, 32'h0, "no capture before fourth edge");
      pulse();
      check("R4", {31'h0, flag_o}, 32'h1, "capture on fourth edge");

      // R5: every sixteenth rising edge
      tag = "R5";
      go_off();
      mode_i = 4'b0111;
      @(negedge clk);
      for (int i = 0; i < 15; i++) pulse();
      check("R5", {31'h0, flag_o}, 32'h0, "no capture before sixteenth edge");
      pulse();
      check("R5", {31'h0, flag_o}, 32'h1, "capture on sixteenth edge");

      // R10: switch between divided modes keeps count
      tag = "R10";
      go_off();
      mode_i = 4'b0110;
      @(negedge clk);
      for (int i = 0; i < 3; i++) pulse();
      mode_i = 4'b0111;
      @(negedge clk);
      for (int i = 0; i < 12; i++) pulse();
      check("R10", {31'h0, flag_o}, 32'h0, "no capture on twelfth edge after switch");
      pulse();
      check("R10", {31'h0, flag_o}, 32'h1, "early capture on thirteenth edge");

      repeat (4) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule